// File: doc/BRIEF.md
# Proximity Detection and Recalibration Controller

This block looks after one sensor stage of a capacitive touch front end. Once per conversion sequence it receives the stage's new fast-filter word, the fast-filter average and the stored ambient level. From these it decides three things: whether an object is near the sensor, whether the ambient-tracking calibration may run, and when the ambient level must be forcibly re-learned.

Two comparators drive the proximity flag. The fast one catches a quick approach from the slope of the fast-filter history. The slow one catches a hand hovering at a steady distance from the gap between the filtered value and ambient. After proximity is seen, calibration stays blocked for a programmable number of sequences. That number is scaled differently in full power and in low power mode. If the filtered value stays away from ambient for a programmable number of sequences in a row, the block issues a force-recalibration pulse. The pulse is followed by a two-sequence hold-off.

Top module: `prox_recal_ctrl`

## Requirements
- R1: After reset, prox_flag is 0, cal_en is 1 and force_recal is 0.
- R2: The fast comparator compares the incoming ff_word with the word received two sequences earlier. It flags proximity only when the absolute difference is strictly greater than rate_thr. It cannot fire until two earlier words have been received since reset.
- R3: The slow comparator flags proximity when |ff_avg - ambient| is strictly greater than recal_lvl. Both directions count. A difference equal to recal_lvl does not flag.
- R4: At every sequence, prox_flag takes the OR of both comparators, so it clears at the first sequence where neither one fires.
- R5: In full power mode (low_power = 0), a sequence with a comparator hit loads a disable count of fp_dis_cnt × 16 sequences. Each later sequence without a hit decrements it by one. Any new hit reloads it.
- R6: In low power mode (low_power = 1), the disable count loaded on a hit is lp_dis_cnt × 4 sequences.
- R7: cal_en is 1 only when prox_flag is 0 and the disable count is zero.
- R8: The disable count, the persistence count and the hold-off count change only in a cycle where seq_done is high. Idle cycles have no effect.
- R9: When the slow comparator has fired in N consecutive sequences, the Nth sequence raises force_recal. N is fp_recal_to in full power and lp_recal_to in low power. A sequence without a slow hit restarts the count. A timeout of 0 never forces.
- R10: force_recal is a one-cycle pulse. At that sequence prox_flag and the disable count are cleared, so cal_en reads 1.
- R11: After a force, the next two sequences neither count persistence nor force. Counting starts again on the third sequence.
- R12: All outputs are registered. They reflect a sequence in the cycle after the one in which seq_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_done | input | 1 | One-cycle strobe, end of a conversion sequence; data inputs valid with it |
| low_power | input | 1 | 1 selects the low power counts |
| ff_word | input | DW | Newest fast-filter word for this stage |
| ff_avg | input | DW | Fast-filter average for this stage |
| ambient | input | DW | Stored ambient level for this stage |
| rate_thr | input | DW | Fast comparator threshold, LSB codes |
| recal_lvl | input | DW | Slow comparator threshold, LSB codes |
| fp_dis_cnt | input | DCW | Full power disable count (×16 sequences) |
| lp_dis_cnt | input | DCW | Low power disable count (×4 sequences) |
| fp_recal_to | input | FTW | Full power persistence timeout, sequences |
| lp_recal_to | input | LTW | Low power persistence timeout, sequences |
| prox_flag | output | 1 | Proximity detected at the last sequence |
| cal_en | output | 1 | Ambient calibration allowed |
| force_recal | output | 1 | One-cycle forced recalibration pulse |

## Verification
Every result in the block is due exactly one clock after the cycle in which seq_done is high. The bench drives the strobe for one cycle from a falling edge and samples the outputs at the next falling edge. At every falling edge it compares all three outputs against a behavioural model that advances on the same rising edge. Counts of sequences are measured by stepping sequences one at a time and reading cal_en or force_recal after each one. Idle gaps of many cycles are inserted to show that nothing moves without a sequence strobe.

// File: rtl/prox_recal_ctrl.sv
`timescale 1ns/1ps
module prox_recal_ctrl #(
  parameter int DW  = 16,
  parameter int DCW = 4,
  parameter int FTW = 8,
  parameter int LTW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seq_done,
  input  logic           low_power,
  input  logic [DW-1:0]  ff_word,
  input  logic [DW-1:0]  ff_avg,
  input  logic [DW-1:0]  ambient,
  input  logic [DW-1:0]  rate_thr,
  input  logic [DW-1:0]  recal_lvl,
  input  logic [DCW-1:0] fp_dis_cnt,
  input  logic [DCW-1:0] lp_dis_cnt,
  input  logic [FTW-1:0] fp_recal_to,
  input  logic [LTW-1:0] lp_recal_to,
  output logic           prox_flag,
  output logic           cal_en,
  output logic           force_recal
);
  localparam int DISW = DCW + 4;
  localparam int TOW  = (FTW > LTW) ? FTW : LTW;

  logic [DW-1:0]   h0_q, h1_q;
  logic [1:0]      fill_q;
  logic            prox_q, force_q;
  logic [DISW-1:0] dis_q, dis_load;
  logic [TOW-1:0]  rc_q, to_sel;
  logic [TOW:0]    rc_inc;
  logic [1:0]      busy_q;
  logic            fast_hit, slow_hit, any_hit, fire;

  function automatic logic [DW:0] absdiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[DW] ? (~d + 1'b1) : d;
  endfunction

  assign fast_hit = (fill_q == 2'd2) && (absdiff(ff_word, h1_q) > {1'b0, rate_thr});
  assign slow_hit = absdiff(ff_avg, ambient) > {1'b0, recal_lvl};
  assign any_hit  = fast_hit | slow_hit;

  assign dis_load = low_power ? DISW'({lp_dis_cnt, 2'b00}) : DISW'({fp_dis_cnt, 4'b0000});
  assign to_sel   = low_power ? TOW'(lp_recal_to) : TOW'(fp_recal_to);
  assign rc_inc   = {1'b0, rc_q} + 1'b1;
  assign fire     = seq_done && slow_hit && (busy_q == 2'd0) && (to_sel != '0)
                    && (rc_inc >= {1'b0, to_sel});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0_q    <= '0;
      h1_q    <= '0;
      fill_q  <= '0;
      prox_q  <= 1'b0;
      force_q <= 1'b0;
      dis_q   <= '0;
      rc_q    <= '0;
      busy_q  <= '0;
    end else begin
      force_q <= 1'b0;
      if (seq_done) begin
        h1_q <= h0_q;
        h0_q <= ff_word;
        if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
        if (fire) begin
          force_q <= 1'b1;
          prox_q  <= 1'b0;
          dis_q   <= '0;
          rc_q    <= '0;
          busy_q  <= 2'd2;
        end else begin
          prox_q <= any_hit;
          if (any_hit)           dis_q <= dis_load;
          else if (dis_q != '0)  dis_q <= dis_q - 1'b1;
          if (busy_q != 2'd0) begin
            busy_q <= busy_q - 2'd1;
            rc_q   <= '0;
          end else if (slow_hit && (to_sel != '0)) begin
            rc_q <= rc_inc[TOW-1:0];
          end else begin
            rc_q <= '0;
          end
        end
      end
    end
  end

  assign prox_flag   = prox_q;
  assign cal_en      = !prox_q && (dis_q == '0);
  assign force_recal = force_q;

  AST_CAL_OFF_IN_PROX: assert property (@(posedge clk) disable iff (!rst_n)
    prox_flag |-> !cal_en); // R7
  AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    force_recal |=> !force_recal); // R10
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_recal |-> (!prox_flag && cal_en)); // R10
  AST_FORCE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    force_recal |-> ($past(busy_q) == 2'd0)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> ($stable(dis_q) && $stable(rc_q) && $stable(busy_q))); // R8
  AST_OUT_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    force_recal |-> $past(seq_done)); // R12
endmodule

// File: tb/prox_recal_ctrl_tb.sv
`timescale 1ns/1ps
module prox_recal_ctrl_tb_top;
  localparam int AMB = 20000;
  logic clk = 1'b0, rst_n = 1'b0, seq_done = 1'b0, low_power = 1'b0;
  logic [15:0] ff_word = '0, ff_avg = 16'(AMB), ambient = 16'(AMB);
  logic [15:0] rate_thr = 16'd100, recal_lvl = 16'd50;
  logic [3:0]  fp_dis_cnt = 4'd2, lp_dis_cnt = 4'd3;
  logic [7:0]  fp_recal_to = 8'd0;
  logic [5:0]  lp_recal_to = 6'd0;
  logic prox_flag, cal_en, force_recal;

  int errors = 0, checks = 0, nforce = 0;
  bit s_prox, s_cal, s_force;

  prox_recal_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .low_power(low_power),
    .ff_word(ff_word), .ff_avg(ff_avg), .ambient(ambient),
    .rate_thr(rate_thr), .recal_lvl(recal_lvl),
    .fp_dis_cnt(fp_dis_cnt), .lp_dis_cnt(lp_dis_cnt),
    .fp_recal_to(fp_recal_to), .lp_recal_to(lp_recal_to),
    .prox_flag(prox_flag), .cal_en(cal_en), .force_recal(force_recal));

  always #2.5 clk = ~clk;

  int m_prox, m_dis, m_rc, m_busy, m_force;
  int q[$];

  function automatic int ad(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prox = 0; m_dis = 0; m_rc = 0; m_busy = 0; m_force = 0; q.delete();
    end else begin
      m_force = 0;
      if (seq_done) begin
        int w, to;
        bit fast, slow, fire;
        w    = int'(ff_word);
        fast = (q.size() == 2) && (ad(w, q[0]) > int'(rate_thr));
        slow = ad(int'(ff_avg), int'(ambient)) > int'(recal_lvl);
        to   = low_power ? int'(lp_recal_to) : int'(fp_recal_to);
        fire = slow && (m_busy == 0) && (to != 0) && (m_rc + 1 >= to);
        q.push_back(w);
        if (q.size() > 2) void'(q.pop_front());
        if (fire) begin
          m_force = 1; m_prox = 0; m_dis = 0; m_rc = 0; m_busy = 2;
        end else begin
          m_prox = (fast || slow) ? 1 : 0;
          if (fast || slow) m_dis = low_power ? int'(lp_dis_cnt) * 4 : int'(fp_dis_cnt) * 16;
          else if (m_dis > 0) m_dis--;
          if (m_busy > 0) begin m_busy--; m_rc = 0; end
          else if (slow && to != 0) m_rc++;
          else m_rc = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(prox_flag == m_prox[0], "R4 prox_flag vs model", int'(prox_flag), m_prox);
      chk(cal_en == (m_prox == 0 && m_dis == 0), "R7 cal_en vs model", int'(cal_en),
          int'(m_prox == 0 && m_dis == 0));
      chk(force_recal == m_force[0], "R10 force_recal vs model", int'(force_recal), m_force);
      if (force_recal) nforce++;
    end
  end

  task automatic seq(input int w, input int avg);
    @(negedge clk);
    ff_word = 16'(w); ff_avg = 16'(avg); seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
    s_prox = prox_flag; s_cal = cal_en; s_force = force_recal;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k, found;
    int fl[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prox_flag == 0 && cal_en == 1 && force_recal == 0, "R1 reset outputs",
        {prox_flag, cal_en, force_recal}, 3'b010);

    seq(1000, AMB);
    seq(5000, AMB);
    chk(s_prox == 0, "R2 fast idle before history", s_prox, 0);
    seq(1100, AMB);
    chk(s_prox == 0, "R2 equal to threshold no flag", s_prox, 0);
    seq(5101, AMB);
    chk(s_prox == 1, "R2 fast above threshold", s_prox, 1);
    chk(s_cal == 0, "R12 registered cal_en drop", s_cal, 0);
    found = 0;
    for (int i = 1; i <= 40; i++) begin
      seq(5101, AMB);
      if (i == 2) chk(s_prox == 0, "R4 prox clears", s_prox, 0);
      if (i == 2) chk(s_cal == 0, "R5 still disabled", s_cal, 0);
      if (s_cal && found == 0) found = i;
    end
    chk(found == 33, "R5 full power disable length", found, 33);

    low_power = 1'b1;
    seq(5101, AMB + 51);
    chk(s_prox == 1, "R3 slow above", s_prox, 1);
    seq(5101, AMB - 51);
    chk(s_prox == 1, "R3 slow below", s_prox, 1);
    seq(5101, AMB + 50);
    chk(s_prox == 0, "R3 equal to level no flag", s_prox, 0);
    repeat (100) @(negedge clk);
    chk(cal_en == 0, "R8 idle gap holds", cal_en, 0);
    found = 0;
    for (int i = 1; i <= 20; i++) begin
      seq(5101, AMB);
      if (s_cal && found == 0) found = i;
    end
    chk(found == 11, "R6 low power disable length", found, 11);
    chk(nforce == 0, "R9 zero timeout never forces", nforce, 0);

    low_power = 1'b0;
    fp_recal_to = 8'd5;
    for (int i = 1; i <= 20; i++) begin
      seq(5101, AMB + 60);
      if (s_force) fl.push_back(i);
      if (i == 5) chk(s_prox == 0 && s_cal == 1, "R10 force clears prox and disable",
                      {s_prox, s_cal}, 2'b01);
      if (i == 6) chk(s_prox == 1, "R4 prox returns after force", s_prox, 1);
    end
    chk(fl.size() == 3, "R11 force count with hold-off", fl.size(), 3);
    if (fl.size() == 3) begin
      chk(fl[0] == 5, "R9 first force sequence", fl[0], 5);
      chk(fl[1] == 12, "R11 second force after hold-off", fl[1], 12);
      chk(fl[2] == 19, "R11 third force", fl[2], 19);
    end

    repeat (3) seq(5101, AMB);
    low_power = 1'b1;
    lp_recal_to = 6'd3;
    k = nforce;
    found = 0;
    for (int i = 1; i <= 6; i++) begin
      seq(5101, (i == 3) ? AMB : AMB + 60);
      if (s_force && found == 0) found = i;
    end
    chk(found == 6, "R9 low power timeout restarts on miss", found, 6);
    chk(nforce - k == 1, "R9 single low power force", nforce - k, 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule